// File: doc/BRIEF.md
# Arbitrary-Sequence Counter

This block steps through a fixed cycle of eight 4-bit values that need not be ordered, distinct or contiguous. A 3-bit binary state register, built from toggle flip-flops, advances by one on every rising clock edge. A purely combinational lookup turns the state into the output value. The output therefore repeats every eight clocks.

The eight output values come from a packed table parameter, with entry 0 in the least significant nibble. The default cycle is 0, 4, 2, 8, 10, 0, 11, 9. The value 0 occurs at state 0 and again at state 5. The output alone therefore does not show where the counter is in its cycle. A user who needs the position must count edges from reset.

Top module: `arb_seq_counter`

## Requirements
- R1: While rst_ni is low, the state is 000 and seq_o shows table entry 0. With the default table this is value 0, and it holds across clock edges for as long as reset stays low.
- R2: After reset is released, the k-th rising edge moves the state to k mod 8, and seq_o becomes table entry k mod 8. With the default table the sequence after reset is 0, 4, 2, 8, 10, 0, 11, 9.
- R3: seq_o is periodic with period eight clocks: the value after edge k equals the value after edge k+8.
- R4: seq_o is a combinational function of the state only, so it changes only after a rising clock edge and stays constant between edges.
- R5: A repeated output value does not disturb the sequence. With the default table, the 0 at state 0 is followed by 4, and the 0 at state 5 is followed by 11.
- R6: Pulling rst_ni low in the middle of a cycle forces seq_o to entry 0 at once, with no clock edge needed. After release, the cycle restarts from entry 0.
- R7: The state wraps from 111 to 000 on the next edge with no extra cycle, so entry 7 (9 by default) is followed directly by entry 0 (0 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state advances on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; sets the state to 000 |
| seq_o | output | 4 | Current sequence value, decoded from the state |

## Verification
The bench runs the counter through two complete cycles from reset and compares every value with the default table. This separates a correct mapping and period from a shifted, reversed or shortened sequence. It also sets the two zero-valued positions side by side and checks what follows each one, which shows whether the state and not the last output drives the next step. A reset applied mid-cycle and a sample taken just before an edge show whether reset is asynchronous and whether the output stays constant between edges.

// File: rtl/arb_seq_pkg.sv
package arb_seq_pkg;
  localparam int unsigned SEQ_STATE_W = 3;
  localparam int unsigned SEQ_OUT_W   = 4;
  localparam int unsigned SEQ_DEPTH   = 1 << SEQ_STATE_W;
  // entry 0 in the low nibble: 0,4,2,8,10,0,11,9
  localparam logic [SEQ_DEPTH*SEQ_OUT_W-1:0] SEQ_DEFAULT_TABLE = 32'h9B0A_8240;
endpackage

// File: rtl/arb_seq_tff.sv
module arb_seq_tff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic t_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= 1'b0;
    else if (t_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/arb_seq_state_ctr.sv
module arb_seq_state_ctr #(
  parameter int unsigned STATE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [STATE_W-1:0] state_o
);
  localparam logic [STATE_W-1:0] STATE_MAX = '1;

  logic [STATE_W-1:0] tog;

  // synchronous toggle chain: bit i flips when all lower bits are 1
  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign tog[i] = 1'b1;
    end else begin : g_upper
      assign tog[i] = &state_o[i-1:0];
    end
    arb_seq_tff u_tff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .t_i   (tog[i]),
      .q_o   (state_o[i])
    );
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_state_R1: assert (state_o == '0)
      else $error("state not cleared in reset");
  end

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (state_o == $past(state_o) + 1'b1));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == STATE_MAX) |=> (state_o == '0));
endmodule

// File: rtl/arb_seq_decode.sv
module arb_seq_decode #(
  parameter int unsigned STATE_W = 3,
  parameter int unsigned OUT_W   = 4,
  parameter int unsigned DEPTH   = 1 << STATE_W,
  parameter logic [DEPTH*OUT_W-1:0] TABLE = '0
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [OUT_W-1:0]   seq_o
);
  always_comb begin
    seq_o = TABLE[state_i*OUT_W +: OUT_W];
  end

  always_comb begin
    assert_known_R4: assert ($isunknown(state_i) || !$isunknown(seq_o))
      else $error("decode output unknown");
  end
endmodule

// File: rtl/arb_seq_counter.sv
module arb_seq_counter
  import arb_seq_pkg::*;
#(
  parameter int unsigned STATE_W = SEQ_STATE_W,
  parameter int unsigned OUT_W   = SEQ_OUT_W,
  parameter logic [(1<<STATE_W)*OUT_W-1:0] SEQ_TABLE = SEQ_DEFAULT_TABLE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] seq_o
);
  localparam int unsigned DEPTH = 1 << STATE_W;

  logic [STATE_W-1:0] state;

  arb_seq_state_ctr #(.STATE_W(STATE_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(state)
  );

  arb_seq_decode #(
    .STATE_W(STATE_W),
    .OUT_W  (OUT_W),
    .DEPTH  (DEPTH),
    .TABLE  (SEQ_TABLE)
  ) u_dec (
    .state_i(state),
    .seq_o  (seq_o)
  );

  assert_reset_out_R6: assert property (@(posedge clk_i)
    !rst_ni |-> (seq_o == SEQ_TABLE[OUT_W-1:0]));
endmodule

// File: tb/arb_seq_counter_tb.sv
module arb_seq_counter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] seq_o;

  int checks = 0;
  int errors = 0;
  int pos    = 0;
  bit done   = 0;
  int exp_tab [8] = '{0, 4, 2, 8, 10, 0, 11, 9};

  always #10 clk_i = ~clk_i;

  arb_seq_counter u_dut (.clk_i(clk_i), .rst_ni(rst_ni), .seq_o(seq_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    pos = (pos + 1) % 8;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 out in reset", int'(seq_o), exp_tab[0]);
    @(posedge clk_i); @(negedge clk_i);
    chk("R1 held over edge", int'(seq_o), exp_tab[0]);
    rst_ni = 1'b1;
    pos = 0;
    #1 chk("R1 after release", int'(seq_o), exp_tab[0]);
  endtask

  task automatic t_two_cycles();
    int first [8];
    for (int k = 0; k < 8; k++) begin
      step();
      first[pos] = int'(seq_o);
      chk(pos == 0 ? "R7 wrap to entry0" : "R2 sequence", int'(seq_o), exp_tab[pos]);
    end
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R3 period 8", int'(seq_o), first[pos]);
    end
  endtask

  task automatic t_stable_between_edges();
    int a;
    for (int k = 0; k < 3; k++) begin
      step();
      a = int'(seq_o);
      #8;
      chk("R4 stable before edge", int'(seq_o), a);
    end
    @(negedge clk_i);
    chk("R4 next value", int'(seq_o), exp_tab[(pos + 1) % 8]);
    pos = (pos + 1) % 8;
  endtask

  task automatic t_repeat_zero();
    while (pos != 0) step();
    chk("R5 zero at state0", int'(seq_o), 0);
    step();
    chk("R5 after first zero", int'(seq_o), 4);
    while (pos != 5) step();
    chk("R5 zero at state5", int'(seq_o), 0);
    step();
    chk("R5 after second zero", int'(seq_o), 11);
  endtask

  task automatic t_mid_reset();
    while (pos != 3) step();
    chk("R6 pre-reset value", int'(seq_o), 8);
    #3 rst_ni = 1'b0;
    #1 chk("R6 async clear", int'(seq_o), exp_tab[0]);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pos = 0;
    step();
    chk("R6 restart entry1", int'(seq_o), exp_tab[1]);
    step();
    chk("R6 restart entry2", int'(seq_o), exp_tab[2]);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_two_cycles();
    t_stable_between_edges();
    t_repeat_zero();
    t_mid_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule